// File: doc/BRIEF.md
# Floating-Point to 32-Bit Integer Converter

The converter accepts a double-precision or single-precision floating-point operand and produces a signed two's-complement integer. A two-bit input selects the rounding direction. Along with the integer, the block reports which exceptions the conversion caused. It also returns an accumulated exception word, which is the caller's previous accumulated flags with the new causes added. A trap request goes high when a caused exception has its enable bit set.

The block has one register stage. An operand presented with `in_valid` high gives its result with `out_valid` high on the next clock. Out-of-range magnitudes are not clamped silently. An overflow or underflow is reported first under its own flag. If that flag's trap is disabled, the event is handed to the inexact trap when that trap is enabled. Otherwise it is reported as an invalid operation. Every exceptional outcome returns the largest positive integer.

Top module: `f2i_convert`

## Requirements
- R1: The outputs register once: an operand taken with `in_valid` high gives `out_valid` high with its result on the following clock, and `out_valid` is low otherwise. Reset clears `out_valid`, `result`, `cause`, `sticky_out` and `trap`.
- R2: An operand whose exponent field is all ones (an infinity or a NaN, of either sign) causes invalid (cause bit 3) and returns 0x7FFFFFFF.
- R3: A zero exponent field with a zero fraction returns 0 with no flags. A zero exponent field with a nonzero fraction returns 0 and causes inexact (cause bit 0) in every rounding mode.
- R4: With `is_double` low, the operand is the single-precision value in `operand[31:0]`. It converts exactly as the equal double-precision value would, including rounding on its lowest fraction bit.
- R5: An unbiased exponent of exactly 31 returns 0x80000000 with no flags only for a negative operand with an all-zero fraction. Every other operand at that exponent overflows.
- R6: An unbiased exponent above 31 overflows (cause bit 2). An unbiased exponent below MIN_EXP (default -1, so magnitudes under 0.5) underflows (cause bit 1). An exponent of exactly MIN_EXP converts normally.
- R7: Rounding mode 01 truncates. Mode 10 adds one to a positive value that has a nonzero fraction. Mode 11 adds one to the magnitude of a negative value that has a nonzero fraction. A nonzero discarded fraction causes inexact.
- R8: Rounding mode 00 rounds to the nearest integer. An exact half rounds to the even integer, and fraction bits of any weight below the half count toward rounding up.
- R9: A magnitude that reaches 2^31 through the rounding increment is an overflow, whatever the sign.
- R10: A negative operand returns the two's complement of its rounded magnitude.
- R11: On overflow or underflow, the block sets that flag. If its enable is off, it then adds inexact when the inexact enable (bit 0) is on, and otherwise adds invalid.
- R12: `sticky_out` equals `sticky_in` OR `cause`. `trap` is high exactly when some cause bit has its `trap_en` bit set. Both use the bit order inexact 0, underflow 1, overflow 2, invalid 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 64 | Double operand, or single operand in bits 31:0 |
| is_double | input | 1 | 1 selects double precision, 0 selects single |
| rmode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| trap_en | input | 4 | Trap enables, one per exception bit |
| sticky_in | input | 4 | Previously accumulated exception flags |
| out_valid | output | 1 | Result present this cycle |
| result | output | INT_W | Signed integer result |
| cause | output | 4 | Exceptions caused by this conversion |
| sticky_out | output | 4 | sticky_in merged with cause |
| trap | output | 1 | Trap request |

## Verification
The bench builds the converter with INT_W = 32 and MIN_EXP = -1. These are the default values, so they match the intended use. With MIN_EXP = -1, the underflow boundary lies between 0.25 and 0.5. Small constants can therefore exercise both sides of it, and the round-to-nearest tie exactly at 0.5. At a 32-bit width, the 2^31 - 0.5 operand rounds into the sign bit and hits the carry overflow. The ±2^31 operands reach the special exponent-31 case. Both paths are driven under every trap-enable combination that changes the escalation.

// File: rtl/f2i_pkg.sv
// Package f2i_pkg
// Shared constants and types for the float-to-integer converter.
// Assumes the exception word order inexact, underflow, overflow, invalid.
package f2i_pkg;

    localparam int NFLAGS = 4;
    localparam int FL_INX = 0;
    localparam int FL_UNF = 1;
    localparam int FL_OVF = 2;
    localparam int FL_INV = 3;

    localparam int SIG_W  = 53;   // double significand including hidden one
    localparam int FRAC_W = 52;
    localparam int EXP_W  = 13;   // signed unbiased exponent width

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        CL_ZERO,
        CL_TINY,
        CL_NORM,
        CL_SPECIAL
    } fclass_e;

    typedef struct packed {
        logic                    sign;
        fclass_e                 cls;
        logic                    frac_nz;
        logic signed [EXP_W-1:0] exp;
        logic [SIG_W-1:0]        sig;
    } unpacked_t;

endpackage

// File: rtl/f2i_unpack.sv
// Module f2i_unpack
// Splits a single- or double-precision operand into sign, class, unbiased
// exponent and a 53-bit significand in double layout. A single fraction is
// shifted up by 29 so that its bits line up with the double fraction.
// Assumes a single operand sits in operand[31:0].
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [63:0] operand,
    input  logic        is_double,
    output unpacked_t   fields
);

    logic [10:0]       exp_field;
    logic              exp_ones;
    logic [FRAC_W-1:0] frac;

    // Select the sign, exponent and fraction of the chosen format
    always_comb begin
        if (is_double) begin
            fields.sign = operand[63];
            exp_field   = operand[62:52];
            exp_ones    = &operand[62:52];
            frac        = operand[51:0];
            fields.exp  = $signed({2'b00, operand[62:52]}) - 13'sd1023;
        end else begin
            fields.sign = operand[31];
            exp_field   = {3'b000, operand[30:23]};
            exp_ones    = &operand[30:23];
            frac        = {operand[22:0], 29'd0};
            fields.exp  = $signed({5'b00000, operand[30:23]}) - 13'sd127;
        end
    end

    // Classify the operand and attach the hidden one
    always_comb begin
        fields.frac_nz = |frac;
        fields.sig     = {1'b1, frac};
        if (exp_ones)
            fields.cls = CL_SPECIAL;
        else if (exp_field == 11'd0)
            fields.cls = fields.frac_nz ? CL_TINY : CL_ZERO;
        else
            fields.cls = CL_NORM;
    end

endmodule

// File: rtl/f2i_align_round.sv
// Module f2i_align_round
// Moves the binary point of the significand to separate the integer part
// from the fraction, then applies the selected rounding increment.
// Assumes the caller uses the outputs only for exponents in
// [MIN_EXP, INT_W-2]; outside that range the shift is parked at its maximum.
module f2i_align_round
    import f2i_pkg::*;
#(
    parameter int INT_W   = 32,
    parameter int MIN_EXP = -1
) (
    input  logic [SIG_W-1:0]        sig,
    input  logic signed [EXP_W-1:0] exp,
    input  logic                    sign,
    input  rmode_e                  rmode,
    output logic [INT_W-1:0]        mag,
    output logic                    inexact,
    output logic                    carry_ovf
);

    localparam int RSH_MAX = FRAC_W - MIN_EXP;
    localparam int EXT_W   = SIG_W + RSH_MAX;
    localparam int SH_W    = $clog2(EXT_W + 1);
    localparam logic signed [EXP_W-1:0] E_LO = EXP_W'(MIN_EXP);
    localparam logic signed [EXP_W-1:0] E_HI = EXP_W'(INT_W - 2);

    logic [SH_W-1:0]    rsh;
    logic [EXT_W-1:0]   ext;
    logic [SIG_W-1:0]   int_part;
    logic [RSH_MAX-1:0] frac_part;
    logic               rnd_bit;
    logic               stk_bit;
    logic               inc;
    logic [INT_W:0]     sum;
    logic               wide;

    // Right shift distance that leaves the integer part above bit RSH_MAX
    always_comb begin
        if (exp >= E_LO && exp <= E_HI)
            rsh = SH_W'(FRAC_W - int'(exp));
        else
            rsh = SH_W'(RSH_MAX);
    end

    // Align the significand and split integer from fraction
    always_comb begin
        ext       = {sig, {RSH_MAX{1'b0}}} >> rsh;
        int_part  = ext[EXT_W-1:RSH_MAX];
        frac_part = ext[RSH_MAX-1:0];
        rnd_bit   = frac_part[RSH_MAX-1];
        stk_bit   = |frac_part[RSH_MAX-2:0];
        wide      = |int_part[SIG_W-1:INT_W];
    end

    // Choose the rounding increment for the requested direction
    always_comb begin
        unique case (rmode)
            RM_NEAR: inc = rnd_bit & (stk_bit | int_part[0]);
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = ~sign & (rnd_bit | stk_bit);
            RM_DOWN: inc = sign & (rnd_bit | stk_bit);
            default: inc = 1'b0;
        endcase
    end

    // Add the increment and flag a magnitude that left the signed range
    always_comb begin
        sum       = {1'b0, int_part[INT_W-1:0]} + {{INT_W{1'b0}}, inc};
        mag       = sum[INT_W-1:0];
        carry_ovf = sum[INT_W] | sum[INT_W-1] | wide;
        inexact   = rnd_bit | stk_bit;
    end

endmodule

// File: rtl/f2i_resolve.sv
// Module f2i_resolve
// Picks the final integer and exception causes from the operand class,
// the exponent range checks and the rounded magnitude, applying the fixed
// escalation of overflow and underflow. Assumes mag is valid whenever the
// exponent lies in [MIN_EXP, INT_W-2].
module f2i_resolve
    import f2i_pkg::*;
#(
    parameter int INT_W   = 32,
    parameter int MIN_EXP = -1
) (
    input  logic                    sign,
    input  fclass_e                 cls,
    input  logic                    frac_nz,
    input  logic signed [EXP_W-1:0] exp,
    input  logic [INT_W-1:0]        mag,
    input  logic                    inexact,
    input  logic                    carry_ovf,
    input  logic [NFLAGS-1:0]       trap_en,
    output logic [INT_W-1:0]        result,
    output logic [NFLAGS-1:0]       cause,
    output logic                    trap
);

    localparam logic signed [EXP_W-1:0] E_LO  = EXP_W'(MIN_EXP);
    localparam logic signed [EXP_W-1:0] E_TOP = EXP_W'(INT_W - 1);
    localparam logic [INT_W-1:0] SAT_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] MOST_NEG = {1'b1, {(INT_W-1){1'b0}}};

    logic ovf_ev;
    logic unf_ev;
    logic inv_ev;
    logic inx_ev;
    logic [INT_W-1:0] value;

    // Detect the range events and the plain result of the operand
    always_comb begin
        ovf_ev = 1'b0;
        unf_ev = 1'b0;
        inv_ev = 1'b0;
        inx_ev = 1'b0;
        value  = '0;
        unique case (cls)
            CL_SPECIAL: inv_ev = 1'b1;
            CL_ZERO:    value  = '0;
            CL_TINY:    inx_ev = 1'b1;
            CL_NORM: begin
                if (exp < E_LO)
                    unf_ev = 1'b1;
                else if (exp > E_TOP)
                    ovf_ev = 1'b1;
                else if (exp == E_TOP) begin
                    if (sign && !frac_nz)
                        value = MOST_NEG;
                    else
                        ovf_ev = 1'b1;
                end else if (carry_ovf)
                    ovf_ev = 1'b1;
                else begin
                    value  = sign ? (~mag + 1'b1) : mag;
                    inx_ev = inexact;
                end
            end
            default: inv_ev = 1'b1;
        endcase
    end

    // Escalate untrapped range events and form the cause word and result
    always_comb begin
        cause         = '0;
        cause[FL_OVF] = ovf_ev;
        cause[FL_UNF] = unf_ev;
        cause[FL_INX] = inx_ev;
        cause[FL_INV] = inv_ev;
        if ((ovf_ev && !trap_en[FL_OVF]) || (unf_ev && !trap_en[FL_UNF])) begin
            if (trap_en[FL_INX])
                cause[FL_INX] = 1'b1;
            else
                cause[FL_INV] = 1'b1;
        end
        result = (ovf_ev || unf_ev || inv_ev) ? SAT_POS : value;
        trap   = |(cause & trap_en);
    end

endmodule

// File: rtl/f2i_convert.sv
// Module f2i_convert
// Top level of the float-to-integer converter: decode, align and round,
// resolve exceptions, then one output register stage. Assumes INT_W is at
// most 53 and MIN_EXP is at most INT_W-2.
module f2i_convert
    import f2i_pkg::*;
#(
    parameter int INT_W   = 32,
    parameter int MIN_EXP = -1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [63:0]       operand,
    input  logic              is_double,
    input  logic [1:0]        rmode,
    input  logic [3:0]        trap_en,
    input  logic [3:0]        sticky_in,
    output logic              out_valid,
    output logic [INT_W-1:0]  result,
    output logic [3:0]        cause,
    output logic [3:0]        sticky_out,
    output logic              trap
);

    unpacked_t          fields;
    logic [INT_W-1:0]   mag;
    logic               inexact;
    logic               carry_ovf;
    logic [INT_W-1:0]   res_c;
    logic [NFLAGS-1:0]  cause_c;
    logic               trap_c;

    f2i_unpack u_unpack (
        .operand   (operand),
        .is_double (is_double),
        .fields    (fields)
    );

    f2i_align_round #(.INT_W(INT_W), .MIN_EXP(MIN_EXP)) u_round (
        .sig       (fields.sig),
        .exp       (fields.exp),
        .sign      (fields.sign),
        .rmode     (rmode_e'(rmode)),
        .mag       (mag),
        .inexact   (inexact),
        .carry_ovf (carry_ovf)
    );

    f2i_resolve #(.INT_W(INT_W), .MIN_EXP(MIN_EXP)) u_resolve (
        .sign      (fields.sign),
        .cls       (fields.cls),
        .frac_nz   (fields.frac_nz),
        .exp       (fields.exp),
        .mag       (mag),
        .inexact   (inexact),
        .carry_ovf (carry_ovf),
        .trap_en   (trap_en),
        .result    (res_c),
        .cause     (cause_c),
        .trap      (trap_c)
    );

    // Output stage: capture a conversion when an operand is presented
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            cause      <= '0;
            sticky_out <= '0;
            trap       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result     <= res_c;
                cause      <= cause_c;
                sticky_out <= sticky_in | cause_c;
                trap       <= trap_c;
            end else begin
                trap <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/f2i_convert_chk.sv
// Module f2i_convert_chk
// Property checker for f2i_convert, attached by bind. Assumes the bit order
// inexact 0, underflow 1, overflow 2, invalid 3 for the exception words.
module f2i_convert_chk #(
    parameter int INT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       sticky_in,
    input logic             out_valid,
    input logic [INT_W-1:0] result,
    input logic [3:0]       cause,
    input logic [3:0]       sticky_out,
    input logic             trap
);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !trap);

    a_r12_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((sticky_out & $past(sticky_in)) == $past(sticky_in))
                     && ((sticky_out & cause) == cause));

    a_r2_exception_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (cause[3] || cause[2] || cause[1]))
            |-> result == {1'b0, {(INT_W-1){1'b1}}});

    a_r11_range_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(cause[2] && cause[1]));

    a_r11_lone_range_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (cause[2] || cause[1]) && !cause[3] && !cause[0]) |-> trap);

    a_r5_most_negative_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result == {1'b1, {(INT_W-1){1'b0}}}) |-> cause == 4'b0000);

endmodule

bind f2i_convert f2i_convert_chk #(.INT_W(INT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .sticky_in  (sticky_in),
    .out_valid  (out_valid),
    .result     (result),
    .cause      (cause),
    .sticky_out (sticky_out),
    .trap       (trap)
);

// File: tb/sim_f2i_convert.sv
`timescale 1ns/1ps
module sim_f2i_convert;

    localparam logic [3:0] INX = 4'b0001;
    localparam logic [3:0] UNF = 4'b0010;
    localparam logic [3:0] OVF = 4'b0100;
    localparam logic [3:0] INV = 4'b1000;
    localparam logic [31:0] SAT = 32'h7FFFFFFF;
    localparam logic [1:0] RN = 2'b00, RZ = 2'b01, RU = 2'b10, RD = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic        is_double = 1'b1;
    logic [1:0]  rmode = 2'b00;
    logic [3:0]  trap_en = '0;
    logic [3:0]  sticky_in = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  cause;
    logic [3:0]  sticky_out;
    logic        trap;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] q_res[$];
    logic [3:0]  q_cause[$];
    logic [3:0]  q_stk[$];
    logic        q_trap[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    f2i_convert #(.INT_W(32), .MIN_EXP(-1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .is_double(is_double), .rmode(rmode), .trap_en(trap_en),
        .sticky_in(sticky_in), .out_valid(out_valid), .result(result),
        .cause(cause), .sticky_out(sticky_out), .trap(trap)
    );

    function automatic logic [63:0] mk_d(input logic s, input int e, input logic [51:0] f);
        return {s, 11'(e + 1023), f};
    endfunction

    function automatic logic [63:0] mk_s(input logic s, input int e, input logic [22:0] f);
        return {32'd0, s, 8'(e + 127), f};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // Driver: present one operand and queue what the requirements predict
    task automatic send(input logic [63:0] op, input logic dbl, input logic [1:0] rm,
                        input logic [3:0] ten, input logic [3:0] stin,
                        input logic [31:0] eres, input logic [3:0] ecause, input string tag);
        @(negedge clk);
        operand   = op;
        is_double = dbl;
        rmode     = rm;
        trap_en   = ten;
        sticky_in = stin;
        in_valid  = 1'b1;
        q_res.push_back(eres);
        q_cause.push_back(ecause);
        q_stk.push_back(stin | ecause);
        q_trap.push_back(|(ecause & ten));
        q_tag.push_back(tag);
    endtask

    task automatic dconv(input logic [63:0] op, input logic [1:0] rm,
                         input logic [31:0] eres, input logic [3:0] ecause, input string tag);
        send(op, 1'b1, rm, 4'b0000, 4'b0000, eres, ecause, tag);
    endtask

    // Monitor: compare each produced result with the head of the queue
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            if (q_res.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R1 unexpected out_valid actual=1 expected=0");
            end else begin
                string t;
                t = q_tag.pop_front();
                check({t, " result"}, 64'(result), 64'(q_res.pop_front()));
                check({t, " cause"}, 64'(cause), 64'(q_cause.pop_front()));
                check({t, " sticky_out R12"}, 64'(sticky_out), 64'(q_stk.pop_front()));
                check({t, " trap R12"}, 64'(trap), 64'(q_trap.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL R1 watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset out_valid", 64'(out_valid), 64'd0);
        check("R1 reset result", 64'(result), 64'd0);
        check("R1 reset cause", 64'(cause), 64'd0);
        check("R1 reset sticky_out", 64'(sticky_out), 64'd0);
        check("R1 reset trap", 64'(trap), 64'd0);

        // Basic and ties-to-even rounding (R8)
        dconv(mk_d(0, 0, 52'h0), RN, 32'd1, 4'b0, "R1 one");
        dconv(mk_d(0, 1, 52'h4000000000000), RN, 32'd2, INX, "R8 2.5 tie even");
        dconv(mk_d(0, 1, 52'hC000000000000), RN, 32'd4, INX, "R8 3.5 tie even");
        dconv(mk_d(0, 1, 52'h6000000000000), RN, 32'd3, INX, "R8 2.75 up");
        dconv(mk_d(0, 1, 52'h2000000000000), RN, 32'd2, INX, "R8 2.25 down");
        dconv(mk_d(0, 1, 52'h4000000000004), RN, 32'd3, INX, "R8 low sticky");

        // Directed modes and negative results (R7, R10)
        dconv(mk_d(0, 1, 52'h4000000000000), RZ, 32'd2, INX, "R7 2.5 trunc");
        dconv(mk_d(0, 1, 52'h4000000000000), RU, 32'd3, INX, "R7 2.5 up");
        dconv(mk_d(0, 1, 52'h4000000000000), RD, 32'd2, INX, "R7 2.5 down");
        dconv(mk_d(1, 1, 52'h4000000000000), RD, 32'hFFFFFFFD, INX, "R7 -2.5 down");
        dconv(mk_d(1, 1, 52'h4000000000000), RU, 32'hFFFFFFFE, INX, "R7 -2.5 up");
        dconv(mk_d(1, 1, 52'h4000000000000), RZ, 32'hFFFFFFFE, INX, "R7 -2.5 trunc");
        dconv(mk_d(1, 1, 52'h4000000000000), RN, 32'hFFFFFFFE, INX, "R10 -2.5 nearest");
        dconv(mk_d(0, 1, 52'h8000000000000), RU, 32'd3, 4'b0, "R7 3.0 exact");
        dconv(mk_d(1, 30, 52'hFFFFFFFC00000), RD, 32'h80000001, 4'b0, "R10 -(2^31-1)");

        // Single precision (R4)
        send(64'h3FC00000, 1'b0, RN, 4'b0, 4'b0, 32'd2, INX, "R4 1.5f");
        send(64'hC0E00000, 1'b0, RN, 4'b0, 4'b0, 32'hFFFFFFF9, 4'b0, "R4 -7f");
        send(mk_s(0, 30, 23'h0), 1'b0, RN, 4'b0, 4'b0, 32'h40000000, 4'b0, "R4 2^30");
        send(mk_s(0, 22, 23'h1), 1'b0, RN, 4'b0, 4'b0, 32'h00400000, INX, "R4 low bit tie");
        send(mk_s(0, 22, 23'h1), 1'b0, RU, 4'b0, 4'b0, 32'h00400001, INX, "R4 low bit up");

        // Zeros and denormals (R3)
        dconv(64'h0, RN, 32'd0, 4'b0, "R3 +0");
        dconv(64'h8000000000000000, RN, 32'd0, 4'b0, "R3 -0");
        dconv(64'h1, RN, 32'd0, INX, "R3 denormal");
        dconv(64'h8000000000000001, RD, 32'd0, INX, "R3 neg denormal down");
        send(64'h00000001, 1'b0, RU, 4'b0, 4'b0, 32'd0, INX, "R3 single denormal");

        // Infinities and NaNs (R2)
        dconv(64'h7FF0000000000000, RN, SAT, INV, "R2 +inf");
        dconv(64'hFFF0000000000000, RN, SAT, INV, "R2 -inf");
        send(64'h7FC00000, 1'b0, RN, 4'b0, 4'b0, SAT, INV, "R2 single NaN");

        // Exponent 31 (R5) and carry overflow (R9)
        dconv(mk_d(1, 31, 52'h0), RN, 32'h80000000, 4'b0, "R5 most negative");
        dconv(mk_d(0, 31, 52'h0), RN, SAT, OVF | INV, "R5 +2^31");
        dconv(mk_d(1, 31, 52'h1), RN, SAT, OVF | INV, "R5 below most negative");
        dconv(mk_d(0, 30, 52'hFFFFFFFC00000), RN, SAT, 4'b0, "R9 max int exact");
        dconv(mk_d(0, 30, 52'hFFFFFFFE00000), RN, SAT, OVF | INV, "R9 round carry");
        dconv(mk_d(0, 30, 52'hFFFFFFFE00000), RZ, SAT, INX, "R9 trunc no carry");
        dconv(mk_d(1, 30, 52'hFFFFFFFE00000), RN, SAT, OVF | INV, "R9 negative carry");

        // Range limits (R6)
        dconv(mk_d(0, 40, 52'h0), RN, SAT, OVF | INV, "R6 large");
        dconv(mk_d(0, -2, 52'h0), RN, SAT, UNF | INV, "R6 0.25 under");
        dconv(mk_d(0, -1, 52'h0), RN, 32'd0, INX, "R6 0.5 nearest");
        dconv(mk_d(0, -1, 52'h0), RU, 32'd1, INX, "R6 0.5 up");
        dconv(mk_d(1, -1, 52'h0), RD, 32'hFFFFFFFF, INX, "R6 -0.5 down");
        dconv(mk_d(0, -1, 52'h8000000000000), RN, 32'd1, INX, "R6 0.75");

        // Escalation order (R11) and traps (R12)
        send(mk_d(0, 40, 52'h0), 1'b1, RN, OVF, 4'b0, SAT, OVF, "R11 ovf trapped");
        send(mk_d(0, 40, 52'h0), 1'b1, RN, INX, 4'b0, SAT, OVF | INX, "R11 ovf to inexact");
        send(mk_d(0, 40, 52'h0), 1'b1, RN, INV, 4'b0, SAT, OVF | INV, "R11 ovf to invalid");
        send(mk_d(0, -2, 52'h0), 1'b1, RN, UNF, 4'b0, SAT, UNF, "R11 unf trapped");
        send(mk_d(0, -2, 52'h0), 1'b1, RN, INX, 4'b0, SAT, UNF | INX, "R11 unf to inexact");
        send(mk_d(0, 30, 52'hFFFFFFFE00000), 1'b1, RN, OVF | INX, 4'b0, SAT, OVF, "R11 carry trapped");
        send(mk_d(0, 1, 52'h4000000000000), 1'b1, RN, INX, 4'b0, 32'd2, INX, "R12 inexact trap");
        send(mk_d(0, 0, 52'h0), 1'b1, RN, 4'hF, 4'b0, 32'd1, 4'b0, "R12 exact no trap");
        send(64'h7FF8000000000000, 1'b1, RN, INV, 4'b0, SAT, INV, "R12 invalid trap");
        send(mk_d(0, 0, 52'h0), 1'b1, RN, 4'b0, 4'b0101, 32'd1, 4'b0, "R12 sticky hold");
        send(mk_d(0, 1, 52'h4000000000000), 1'b1, RN, 4'b0, 4'b1000, 32'd2, INX, "R12 sticky merge");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 one result per operand", 64'(q_res.size()), 64'd0);
        check("R1 idle out_valid", 64'(out_valid), 64'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule